// File: doc/BRIEF.md
# Calendar Clock Register Block with Deferred Commit

This block holds the time of day and the calendar date of a real-time clock and presents them on a simple 32-bit register bus. The time register holds seconds, minutes and hours. The date register holds the day, the month, a six-bit year count relative to 1970 (so 1970 to 2033) and a leap-year flag. A one-second tick input advances the clock, with full carry from seconds through to the year.

Software writes to the time or date register are not applied at once. Each write is captured into a holding stage, and a busy flag for that register is raised and shown in the control register. After a fixed number of core cycles the held value is loaded into the live counters and the flag drops. Software polls the flag before it writes again.

The control register also selects the low-speed oscillator source. Writes to it take effect only when the upper half-word carries an unlock key. Reads use a registered data path: the value is sampled on the clock edge where the read strobe is high.

Top module: `rtc_cal_regs`

## Requirements
- R1: After reset, the control register reads 0x00000000, the time register reads 0 (00:00:00), and the date register reads day 1, month 1, year offset 0, leap 0 (0x00000101).
- R2: A write to offset 0x00 whose bits 31:16 equal 0x16AA sets the oscillator select (control bit 0, port `osc_ext`, 1 = external) from write bit 0. A write to offset 0x00 with any other upper half-word leaves the oscillator select unchanged.
- R3: Control reads return the oscillator select in bit 0, the date busy flag in bit 7 and the time busy flag in bit 8. All other bits, including the key field 31:16, read as 0, and written values in those bits have no effect.
- R4: A write to the time register (offset 0x14: seconds 5:0, minutes 13:8, hours 20:16) sets control bit 8 for exactly COMMIT_CYC cycles. Time reads return the old value until the commit, and the new value from the first read after it.
- R5: A write to the date register (offset 0x10: day 4:0, month 11:8, year offset 21:16, leap 22) sets control bit 7 for exactly COMMIT_CYC cycles, and the written date is readable after the commit. The two registers commit independently.
- R6: A time or date write issued while that register's busy flag is set is discarded. The value that commits is the one from the accepted write.
- R7: On each tick, seconds advance and wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours, and hours wrap from 23 to 0 with a carry into the date.
- R8: A day carry advances the day until it reaches the month length (31, 30 for months 4, 6, 9 and 11, and February 28 or 29 according to the leap flag), then sets the day to 1 and advances the month.
- R9: A month carry out of month 12 sets the month to 1 and increments the year offset, wrapping from 63 to 0. It sets the leap flag when the new offset has its two low bits equal to binary 10 (1972, 1976, ...) and clears it otherwise.
- R10: A tick in the same cycle as a time or date commit is discarded. The committed value is loaded exactly, and the next tick advances it normally.
- R11: Offsets other than 0x00, 0x10 and 0x14 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is registered on this edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data from the most recent read strobe |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| osc_ext | output | 1 | Oscillator select: 1 external, 0 internal |

## Verification
A stuck or short commit countdown shows up as a busy bit that is wrong on a control read within COMMIT_CYC+1 cycles of the write. A corrupted holding stage appears as the wrong value on the first time or date read after the commit. A carry fault in the calendar appears on the first read after the single tick that crosses a minute, hour, day, month or year boundary. Each boundary is therefore reached by loading a value one second before it, so a fault is exposed one cycle after the tick. A dropped-write or collision fault shows as a readback that differs from the value accepted first.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int SEC_W = 6;
   localparam int MIN_W = 6;
   localparam int HR_W  = 5;
   localparam int DAY_W = 5;
   localparam int MON_W = 4;
   localparam int YR_W  = 6;

   typedef struct packed {
      logic [HR_W-1:0]  hr;
      logic [MIN_W-1:0] mn;
      logic [SEC_W-1:0] sc;
   } hms_t;

   typedef struct packed {
      logic             leap;
      logic [YR_W-1:0]  yr;
      logic [MON_W-1:0] mo;
      logic [DAY_W-1:0] dy;
   } ymd_t;

   localparam int HMS_W = $bits(hms_t);
   localparam int YMD_W = $bits(ymd_t);

   // last day of a month; February follows the leap flag
   function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mo,
                                                   input logic leap);
      case (mo)
         4'd2:                     return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
         default:                  return 5'd31;
      endcase
   endfunction

   // year offset counts from 1970, so leap years sit where offset mod 4 == 2
   function automatic logic leap_of(input logic [YR_W-1:0] yr);
      return (yr[1:0] == 2'b10);
   endfunction

   function automatic hms_t hms_from_word(input logic [31:0] w);
      hms_t t;
      t.sc = w[5:0];
      t.mn = w[13:8];
      t.hr = w[20:16];
      return t;
   endfunction

   function automatic ymd_t ymd_from_word(input logic [31:0] w);
      ymd_t d;
      d.dy   = w[4:0];
      d.mo   = w[11:8];
      d.yr   = w[21:16];
      d.leap = w[22];
      return d;
   endfunction

   function automatic logic [31:0] hms_to_word(input hms_t t);
      return {11'b0, t.hr, 2'b0, t.mn, 2'b0, t.sc};
   endfunction

   function automatic logic [31:0] ymd_to_word(input ymd_t d);
      return {9'b0, d.leap, d.yr, 4'b0, d.mo, 3'b0, d.dy};
   endfunction

endpackage

// File: rtl/rtc_commit_slot.sv
module rtc_commit_slot #(
   parameter int W          = 17,
   parameter int COMMIT_CYC = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   input  logic [W-1:0] din,
   output logic         busy,
   output logic [W-1:0] dout,
   output logic         commit
);

   logic         busy_q;
   logic [W-1:0] hold_q;
   logic         accept;

   assign accept = req && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (accept) begin
         hold_q <= din;
      end
   end

   generate
      if (COMMIT_CYC == 1) begin : g_single
         assign commit = busy_q;
      end else begin : g_count
         localparam int CW = $clog2(COMMIT_CYC + 1);
         logic [CW-1:0] left_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (accept) begin
               left_q <= CW'(COMMIT_CYC);
            end else if (busy_q) begin
               left_q <= left_q - CW'(1);
            end
         end

         assign commit = busy_q && (left_q == CW'(1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
      end else if (commit) begin
         busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign dout = hold_q;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load_hms,
   input  hms_t hms_in,
   input  logic load_ymd,
   input  ymd_t ymd_in,
   output hms_t hms_cur,
   output ymd_t ymd_cur
);

   hms_t hms_q, hms_nx;
   ymd_t ymd_q, ymd_nx;
   logic sc_end, mn_end, hr_end, day_carry;
   logic dy_end, mo_end;
   logic tick_ok;
   logic [YR_W-1:0] yr_inc;

   assign tick_ok = tick && !load_hms && !load_ymd;

   always_comb begin
      sc_end    = (hms_q.sc >= SEC_W'(59));
      mn_end    = (hms_q.mn >= MIN_W'(59));
      hr_end    = (hms_q.hr >= HR_W'(23));
      day_carry = sc_end && mn_end && hr_end;

      hms_nx    = hms_q;
      hms_nx.sc = sc_end ? '0 : hms_q.sc + SEC_W'(1);
      if (sc_end) begin
         hms_nx.mn = mn_end ? '0 : hms_q.mn + MIN_W'(1);
      end
      if (sc_end && mn_end) begin
         hms_nx.hr = hr_end ? '0 : hms_q.hr + HR_W'(1);
      end
   end

   always_comb begin
      dy_end = (ymd_q.dy >= month_days(ymd_q.mo, ymd_q.leap));
      mo_end = (ymd_q.mo >= MON_W'(12));
      yr_inc = ymd_q.yr + YR_W'(1);

      ymd_nx    = ymd_q;
      ymd_nx.dy = dy_end ? DAY_W'(1) : ymd_q.dy + DAY_W'(1);
      if (dy_end) begin
         ymd_nx.mo = mo_end ? MON_W'(1) : ymd_q.mo + MON_W'(1);
      end
      if (dy_end && mo_end) begin
         ymd_nx.yr   = yr_inc;
         ymd_nx.leap = leap_of(yr_inc);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hms_q <= '0;
      end else if (load_hms) begin
         hms_q <= hms_in;
      end else if (tick_ok) begin
         hms_q <= hms_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ymd_q.dy   <= DAY_W'(1);
         ymd_q.mo   <= MON_W'(1);
         ymd_q.yr   <= '0;
         ymd_q.leap <= 1'b0;
      end else if (load_ymd) begin
         ymd_q <= ymd_in;
      end else if (tick_ok && day_carry) begin
         ymd_q <= ymd_nx;
      end
   end

   assign hms_cur = hms_q;
   assign ymd_cur = ymd_q;

endmodule

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
   import rtc_cal_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          COMMIT_CYC = 4,
   parameter logic [15:0] KEY        = 16'h16AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick_1hz,
   output logic              osc_ext
);

   localparam int SLOT_W   = (HMS_W > YMD_W) ? HMS_W : YMD_W;
   localparam int N_SLOT   = 2;
   localparam int SLOT_YMD = 0;   // busy flag lands in control bit 7
   localparam int SLOT_HMS = 1;   // busy flag lands in control bit 8
   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] OFS_DATE = ADDR_W'(8'h10);
   localparam logic [ADDR_W-1:0] OFS_TIME = ADDR_W'(8'h14);

   generate
      if (COMMIT_CYC < 1) begin : g_bad_commit
         $error("rtc_cal_regs: COMMIT_CYC must be at least 1");
      end
      if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
         $error("rtc_cal_regs: ADDR_W must lie in 5..16");
      end
   endgenerate

   logic hit_ctrl, hit_date, hit_time;
   logic osc_q;
   logic [31:0] rd_mux;
   logic [31:0] rdata_q;

   logic [N_SLOT-1:0] s_req, s_busy, s_commit;
   logic [SLOT_W-1:0] s_din  [N_SLOT];
   logic [SLOT_W-1:0] s_dout [N_SLOT];

   hms_t hms_held, hms_cur;
   ymd_t ymd_held, ymd_cur;

   assign hit_ctrl = (bus_addr == OFS_CTRL);
   assign hit_date = (bus_addr == OFS_DATE);
   assign hit_time = (bus_addr == OFS_TIME);

   // keyed oscillator select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_q <= 1'b0;
      end else if (bus_wr && hit_ctrl && (bus_wdata[31:16] == KEY)) begin
         osc_q <= bus_wdata[0];
      end
   end

   always_comb begin
      s_req[SLOT_YMD] = bus_wr && hit_date;
      s_req[SLOT_HMS] = bus_wr && hit_time;
      s_din[SLOT_YMD] = SLOT_W'(ymd_from_word(bus_wdata));
      s_din[SLOT_HMS] = SLOT_W'(hms_from_word(bus_wdata));
   end

   generate
      for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
         rtc_commit_slot #(
            .W          (SLOT_W),
            .COMMIT_CYC (COMMIT_CYC)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (s_req[i]),
            .din    (s_din[i]),
            .busy   (s_busy[i]),
            .dout   (s_dout[i]),
            .commit (s_commit[i])
         );
      end
   endgenerate

   assign ymd_held = ymd_t'(s_dout[SLOT_YMD][YMD_W-1:0]);
   assign hms_held = hms_t'(s_dout[SLOT_HMS][HMS_W-1:0]);

   rtc_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_1hz),
      .load_hms (s_commit[SLOT_HMS]),
      .hms_in   (hms_held),
      .load_ymd (s_commit[SLOT_YMD]),
      .ymd_in   (ymd_held),
      .hms_cur  (hms_cur),
      .ymd_cur  (ymd_cur)
   );

   always_comb begin
      rd_mux = '0;
      if (hit_ctrl) begin
         rd_mux = {23'b0, s_busy[SLOT_HMS], s_busy[SLOT_YMD], 6'b0, osc_q};
      end else if (hit_date) begin
         rd_mux = ymd_to_word(ymd_cur);
      end else if (hit_time) begin
         rd_mux = hms_to_word(hms_cur);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         rdata_q <= rd_mux;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_wdata[15:14], bus_wdata[7:6], s_dout[SLOT_YMD]};

   assign bus_rdata = rdata_q;
   assign osc_ext   = osc_q;

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
   import rtc_cal_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          COMMIT_CYC = 4,
   parameter logic [15:0] KEY        = 16'h16AA
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              osc_ext,
   input logic [1:0]        busy,
   input logic [1:0]        commit,
   input logic              tick,
   input hms_t              hms_cur,
   input hms_t              hms_held
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(8'h10);
   localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(8'h14);

   logic [15:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (busy[1]) begin
         if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
      end else begin
         run_q <= '0;
      end
   end

   AST_KEYLESS_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL && bus_wdata[31:16] != KEY) |=> $stable(osc_ext)); // R2

   AST_TIME_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_TIME && !busy[1]) |=> busy[1]); // R4

   AST_TIME_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy[1] |-> (run_q < 16'(COMMIT_CYC))); // R4

   AST_COMMIT_LOADS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[1]) |-> (hms_cur == $past(hms_held))); // R4

   AST_DATE_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DATE && !busy[0]) |=> busy[0]); // R5

   AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_TIME && busy[1]) |=> $stable(hms_held)); // R6

   AST_SECOND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && commit == 2'b00 && hms_cur.sc < 6'd59)
      |=> (hms_cur.sc == 6'($past(hms_cur.sc) + 6'd1))); // R7

   AST_COLLIDE_TICK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && commit[1]) |=> (hms_cur == $past(hms_held))); // R10

endmodule

bind rtc_cal_regs rtc_cal_checker #(
   .ADDR_W     (ADDR_W),
   .COMMIT_CYC (COMMIT_CYC),
   .KEY        (KEY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .osc_ext   (osc_ext),
   .busy      (s_busy),
   .commit    (s_commit),
   .tick      (tick_1hz),
   .hms_cur   (hms_cur),
   .hms_held  (hms_held)
);

// File: tb/tb_rtc_cal_regs.sv
module tb_rtc_cal_regs;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 8;
   localparam int COMMIT_CYC = 4;
   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_DATE = 8'h10;
   localparam logic [7:0] A_TIME = 8'h14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              tick_1hz = 1'b0;
   logic              osc_ext;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_cal_regs #(.ADDR_W(ADDR_W), .COMMIT_CYC(COMMIT_CYC)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_1hz(tick_1hz), .osc_ext(osc_ext)
   );

   int          n_run  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   function automatic logic [31:0] tv(int h, int m, int s);
      return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
   endfunction

   function automatic logic [31:0] dv(int l, int y, int mo, int d);
      return (32'(l) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
   endfunction

   // monitor: compares each registered read result against the scoreboard
   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      logic [31:0] e;
      string       t;
      if (rd_seen && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_run++;
         if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: read 0x%08h, expected 0x%08h", t, bus_rdata, e);
         end
      end
   end

   task automatic drive(bit wr, bit rd, bit tk, logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; tick_1hz = tk; bus_addr = a; bus_wdata = d;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      drive(1'b1, 1'b0, 1'b0, a, d);
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      drive(1'b0, 1'b1, 1'b0, a, 32'h0);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
   endtask

   task automatic tick1();
      drive(1'b0, 1'b0, 1'b1, 8'h00, 32'h0);
   endtask

   task automatic set_both(logic [31:0] t, logic [31:0] d);
      wr(A_TIME, t);
      wr(A_DATE, d);
      idle(COMMIT_CYC + 1);
   endtask

   task automatic chk_osc(logic e, string tag);
      n_run++;
      if (osc_ext !== e) begin
         n_fail++;
         $display("FAIL %s: osc_ext %0b, expected %0b", tag, osc_ext, e);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // a day rollover case: load 23:59:59 plus a date, tick once, read back
   task automatic day_case(logic [31:0] d0, logic [31:0] d1, string tag);
      set_both(tv(23, 59, 59), d0);
      tick1();
      rd(A_TIME, tv(0, 0, 0), tag);
      rd(A_DATE, d1, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): run incomplete, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, 32'h0, "R1 control after reset");
      rd(A_TIME, tv(0, 0, 0), "R1 time after reset");
      rd(A_DATE, dv(0, 0, 1, 1), "R1 date after reset");

      // R2 / R3 keyed control
      wr(A_CTRL, 32'h0000_0001);
      rd(A_CTRL, 32'h0, "R2 keyless control write ignored");
      chk_osc(1'b0, "R2 keyless write osc");
      wr(A_CTRL, 32'h16AA_FFFF);
      rd(A_CTRL, 32'h0000_0001, "R3 key and unused bits read zero");
      chk_osc(1'b1, "R2 keyed write osc");
      wr(A_CTRL, 32'h16A9_0000);
      rd(A_CTRL, 32'h0000_0001, "R2 wrong key ignored");
      chk_osc(1'b1, "R2 wrong key osc");
      wr(A_CTRL, 32'h16AA_0000);
      rd(A_CTRL, 32'h0, "R2 keyed clear");
      chk_osc(1'b0, "R2 keyed clear osc");

      // R4 time commit window
      wr(A_TIME, tv(1, 2, 3));
      rd(A_TIME, tv(0, 0, 0), "R4 old time while pending");
      rd(A_CTRL, 32'h100, "R4 busy cycle 2");
      rd(A_CTRL, 32'h100, "R4 busy cycle 3");
      rd(A_CTRL, 32'h100, "R4 busy cycle 4");
      rd(A_CTRL, 32'h000, "R4 busy cleared after commit");
      rd(A_TIME, tv(1, 2, 3), "R4 new time after commit");

      // R6 write while time busy dropped
      wr(A_TIME, tv(5, 6, 7));
      wr(A_TIME, tv(9, 9, 9));
      idle(COMMIT_CYC);
      rd(A_TIME, tv(5, 6, 7), "R6 time write during busy dropped");

      // R5 date commit, independent of time
      wr(A_TIME, tv(2, 0, 0));
      wr(A_DATE, dv(1, 2, 2, 28));
      rd(A_CTRL, 32'h180, "R5 both busy");
      rd(A_CTRL, 32'h180, "R5 both busy");
      rd(A_CTRL, 32'h180, "R5 both busy");
      rd(A_CTRL, 32'h080, "R5 date still busy after time commit");
      rd(A_CTRL, 32'h000, "R5 date busy cleared");
      rd(A_DATE, dv(1, 2, 2, 28), "R5 date after commit");

      // R6 date
      wr(A_DATE, dv(0, 5, 3, 3));
      wr(A_DATE, dv(0, 6, 6, 6));
      idle(COMMIT_CYC + 1);
      rd(A_DATE, dv(0, 5, 3, 3), "R6 date write during busy dropped");

      // R7 time carries
      set_both(tv(0, 0, 59), dv(0, 1, 6, 10));
      tick1();
      rd(A_TIME, tv(0, 1, 0), "R7 second wrap");
      set_both(tv(0, 59, 59), dv(0, 1, 6, 10));
      tick1();
      rd(A_TIME, tv(1, 0, 0), "R7 minute wrap");
      rd(A_DATE, dv(0, 1, 6, 10), "R7 no date carry");
      tick1();
      rd(A_TIME, tv(1, 0, 1), "R7 plain step");
      day_case(dv(0, 1, 6, 10), dv(0, 1, 6, 11), "R7 hour wrap carries day");

      // R8 month lengths
      day_case(dv(1, 2, 2, 28), dv(1, 2, 2, 29), "R8 leap Feb 28");
      day_case(dv(1, 2, 2, 29), dv(1, 2, 3, 1), "R8 leap Feb 29");
      day_case(dv(0, 1, 2, 28), dv(0, 1, 3, 1), "R8 common Feb 28");
      day_case(dv(0, 1, 4, 30), dv(0, 1, 5, 1), "R8 30-day month");
      day_case(dv(0, 1, 1, 30), dv(0, 1, 1, 31), "R8 31-day month day 30");

      // R9 year carry and leap recompute
      day_case(dv(0, 1, 12, 31), dv(1, 2, 1, 1), "R9 year into leap");
      day_case(dv(1, 2, 12, 31), dv(0, 3, 1, 1), "R9 year out of leap");
      day_case(dv(0, 63, 12, 31), dv(0, 0, 1, 1), "R9 year offset wrap");

      // R10 tick colliding with commit
      wr(A_TIME, tv(10, 20, 30));
      idle(COMMIT_CYC - 1);
      tick1();
      rd(A_TIME, tv(10, 20, 30), "R10 collided tick dropped");
      rd(A_DATE, dv(0, 0, 1, 1), "R10 date untouched");
      tick1();
      rd(A_TIME, tv(10, 20, 31), "R10 next tick advances");

      // R11 unmapped offsets
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h08, 32'h0, "R11 unmapped read zero");
      rd(8'h04, 32'h0, "R11 unmapped read zero");
      rd(A_TIME, tv(10, 20, 31), "R11 time unchanged");
      rd(A_CTRL, 32'h0, "R11 control unchanged");

      idle(3);
      finish_run();
   end

endmodule